// File: doc/BRIEF.md
# Coprocessor Host Handshake Interface

This block sits between a host processor bus and the core of a numeric coprocessor. The host addresses the coprocessor through two select lines, a two-bit command and a pair of active-low read and write strobes. None of these pins, and none of the operand acknowledge pins, are related to the local clock. Every one of them passes through a synchroniser. Each selected strobe is then acted on exactly once: the falling edge begins a transfer and the rising edge completes it.

Words written by the host go to the core on a valid/ready stream, tagged with their command. Words the core wants the host to read arrive on a second valid/ready stream and sit in a one-word read hold until a host read completes. On the write stream a word stays presented, with data and tag unchanged, until the core takes it. The core must take it before the next host write begins. On the read stream the block accepts a word only while its hold is empty (`cr_ready_o` high).

The block drives the busy flag while an instruction runs and reflects the core's error flag. It also runs the operand request/acknowledge channel for multi-word memory operands. The word count comes from a two-bit memory-format field. A counting-only mode covers hosts whose acknowledge pin is tied high.

Top module: `cop_host_if`

## Requirements
- R1: A host strobe acts only when `sel_lo_n_i` is 0 and `sel_hi_i` is 1. With any other select pair, a strobe presents no write word, sets no busy and enables no read drive.
- R2: Command value 2'b11 causes no action, even when the device is selected. Commands 2'b00 (instruction), 2'b01 (operand data) and 2'b10 (auxiliary) are acted on.
- R3: A selected write presents exactly one word on the write stream. `cw_valid_o` rises on the third rising clock edge after the write strobe falls, carrying `hdata_i` and the command. The word is held stable while `cw_ready_i` is low.
- R4: A selected read drives `hdata_oe_o` high from the third clock edge after the read strobe falls until the third edge after it rises, presenting the held word on `hdata_o`. When the read completes the hold empties, so `cr_ready_o` returns high.
- R5: Completion of a write with command 2'b00 raises `busy_o` on the third edge after the strobe rises. `busy_o` stays high until `exec_done_i` is sampled high. Writes with other commands leave `busy_o` unchanged.
- R6: `err_o` follows `exec_err_i` one clock later. While busy, `busy_o` falls one clock after `err_o` rises.
- R7: An `op_start_i` pulse loads the word count from `op_fmt_i` and raises `req_o` on the next edge. The counts are 2'b00 → 2 words, 2'b01 → 2, 2'b10 → 4 and 2'b11 → 1.
- R8: A selected command-2'b01 transfer lowers `req_o` three edges after its strobe falls. When the transfer completes, one word is counted off. `req_o` rises again, three edges after the strobe rises, only if words remain.
- R9: In normal mode (`cnt_only_i` = 0), a rising edge of `ack_i` while one word remains lowers `req_o` three edges later, before the transfer itself.
- R10: A rising edge of `ack_i` while more than one word remains leaves `req_o` high.
- R11: With `cnt_only_i` = 1, `ack_i` has no effect on `req_o`, and the transfer ends only by the word count.
- R12: After reset `busy_o`, `err_o`, `req_o`, `hdata_oe_o` and `cw_valid_o` are 0, and `cr_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lo_n_i | input | 1 | Select, active low (asynchronous) |
| sel_hi_i | input | 1 | Select, active high (asynchronous) |
| cmd_i | input | 2 | Host command from address bits (asynchronous) |
| rd_n_i | input | 1 | Host read strobe, active low (asynchronous) |
| wr_n_i | input | 1 | Host write strobe, active low (asynchronous) |
| ack_i | input | 1 | Operand request acknowledge (asynchronous) |
| cnt_only_i | input | 1 | 1 = ignore acknowledge, end by counting |
| hdata_i | input | DATA_W | Host write data |
| hdata_o | output | DATA_W | Host read data |
| hdata_oe_o | output | 1 | Host read data drive enable |
| busy_o | output | 1 | Instruction in progress |
| err_o | output | 1 | Unmasked error flag |
| req_o | output | 1 | Operand word transfer request |
| cw_valid_o | output | 1 | Write stream valid |
| cw_ready_i | input | 1 | Write stream ready |
| cw_data_o | output | DATA_W | Write stream word |
| cw_cmd_o | output | 2 | Command tag of the write stream word |
| cr_valid_i | input | 1 | Read stream valid |
| cr_ready_o | output | 1 | Read stream ready (hold empty) |
| cr_data_i | input | DATA_W | Read stream word |
| op_start_i | input | 1 | Pulse: start operand transfer |
| op_fmt_i | input | 2 | Memory-format field of the operand |
| exec_done_i | input | 1 | Pulse: instruction finished |
| exec_err_i | input | 1 | Core error level |

## Verification
The assertions assume that the core drains the write stream before the next host write begins. They also assume that the host holds `hdata_i`, the select lines and the command steady for the whole strobe, and that a transfer is started only when no words are pending. The stimulus keeps to all of this. The bench raises `cw_ready_i` before each following write. It changes select, command and data only while no strobe is low. It issues `op_start_i` only after the previous operand's words are all counted off. Every strobe and acknowledge level is held for at least three clocks, so each passes the synchroniser and is seen as an edge.

// File: rtl/cop_host_pkg.sv
package cop_host_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    CMD_INSTR = 2'b00,
    CMD_DATA  = 2'b01,
    CMD_AUX   = 2'b10,
    CMD_NONE  = 2'b11
  } host_cmd_e;

  // memory-format field to operand length in words
  function automatic logic [CNT_W-1:0] fmt_words(input logic [1:0] fmt);
    case (fmt)
      2'b00:   return CNT_W'(2);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/cop_sync.sv
module cop_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cop_xfer_chan.sv
module cop_xfer_chan
  import cop_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] fmt_i,
  input  logic       xfer_begin_i,
  input  logic       xfer_end_i,
  input  logic       ack_rise_i,
  input  logic       cnt_only_i,
  output logic       req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= fmt_words(fmt_i);
      req_q <= 1'b1;
    end else if (xfer_end_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      req_q <= (cnt_q > CNT_W'(1));
    end else if (xfer_begin_i) begin
      req_q <= 1'b0;
    end else if (ack_rise_i && !cnt_only_i && cnt_q == CNT_W'(1)) begin
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  // R7: a request is never raised with no words pending
  a_r7_req_has_words: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> cnt_q != '0);

  // R11: in counting-only mode acknowledge cannot move the request
  a_r11_ack_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_only_i && !start_i && !xfer_begin_i && !xfer_end_i) |=> $stable(req_o));

  // R10: acknowledge before the last word leaves the request alone
  a_r10_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise_i && cnt_q > CNT_W'(1) && !start_i && !xfer_begin_i && !xfer_end_i)
      |=> $stable(req_o));

  // R8: a completed transfer counts off exactly one word
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end_i && !start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/cop_busy_ctl.sv
module cop_busy_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_end_i,
  input  logic done_i,
  input  logic err_i,
  output logic busy_o,
  output logic err_o
);
  logic busy_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_i;
      if (instr_end_i)                 busy_q <= 1'b1;
      else if (done_i || err_q)        busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  // R6: busy is released the cycle after the error flag is seen
  a_r6_release_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && err_o && !instr_end_i) |=> !busy_o);

  // R5: busy only rises from a completed instruction write
  a_r5_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(instr_end_i));
endmodule

// File: rtl/cop_host_if.sv
module cop_host_if
  import cop_host_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lo_n_i,
  input  logic              sel_hi_i,
  input  logic [1:0]        cmd_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              ack_i,
  input  logic              cnt_only_i,
  input  logic [DATA_W-1:0] hdata_i,
  output logic [DATA_W-1:0] hdata_o,
  output logic              hdata_oe_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              req_o,
  output logic              cw_valid_o,
  input  logic              cw_ready_i,
  output logic [DATA_W-1:0] cw_data_o,
  output logic [1:0]        cw_cmd_o,
  input  logic              cr_valid_i,
  output logic              cr_ready_o,
  input  logic [DATA_W-1:0] cr_data_i,
  input  logic              op_start_i,
  input  logic [1:0]        op_fmt_i,
  input  logic              exec_done_i,
  input  logic              exec_err_i
);
  localparam int SW = 7;
  localparam logic [SW-1:0] SYNC_RST = 7'b1011110;

  logic [SW-1:0] sync_q;
  logic          s_sel_n, s_sel, s_rd_n, s_wr_n, s_ack;
  logic [1:0]    s_cmd;
  logic          p_rd_n, p_wr_n, p_ack;

  cop_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sel_lo_n_i, sel_hi_i, cmd_i, rd_n_i, wr_n_i, ack_i}),
    .q    (sync_q)
  );

  assign {s_sel_n, s_sel, s_cmd, s_rd_n, s_wr_n, s_ack} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rd_n <= 1'b1;
      p_wr_n <= 1'b1;
      p_ack  <= 1'b0;
    end else begin
      p_rd_n <= s_rd_n;
      p_wr_n <= s_wr_n;
      p_ack  <= s_ack;
    end
  end

  logic rd_fall, rd_rise, wr_fall, wr_rise, ack_rise, selected;
  assign rd_fall  = p_rd_n & ~s_rd_n;
  assign rd_rise  = ~p_rd_n & s_rd_n;
  assign wr_fall  = p_wr_n & ~s_wr_n;
  assign wr_rise  = ~p_wr_n & s_wr_n;
  assign ack_rise = s_ack & ~p_ack;
  assign selected = ~s_sel_n & s_sel & (s_cmd != CMD_NONE);

  // transfer tracking: one begin and one end per selected strobe
  logic       act_q, act_rd_q;
  logic [1:0] act_cmd_q;
  logic       begin_ev, end_ev;

  assign begin_ev = !act_q && selected && (rd_fall || wr_fall);
  assign end_ev   = act_q && (act_rd_q ? rd_rise : wr_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      act_rd_q  <= 1'b0;
      act_cmd_q <= CMD_NONE;
    end else if (begin_ev) begin
      act_q     <= 1'b1;
      act_rd_q  <= ~wr_fall;
      act_cmd_q <= s_cmd;
    end else if (end_ev) begin
      act_q     <= 1'b0;
    end
  end

  // write stream hold
  logic              wh_valid_q;
  logic [DATA_W-1:0] wh_data_q;
  logic [1:0]        wh_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wh_valid_q <= 1'b0;
      wh_data_q  <= '0;
      wh_cmd_q   <= CMD_NONE;
    end else if (begin_ev && wr_fall) begin
      wh_valid_q <= 1'b1;
      wh_data_q  <= hdata_i;
      wh_cmd_q   <= s_cmd;
    end else if (wh_valid_q && cw_ready_i) begin
      wh_valid_q <= 1'b0;
    end
  end

  assign cw_valid_o = wh_valid_q;
  assign cw_data_o  = wh_data_q;
  assign cw_cmd_o   = wh_cmd_q;

  // read stream hold
  logic              rh_full_q;
  logic [DATA_W-1:0] rh_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_full_q <= 1'b0;
      rh_data_q <= '0;
    end else if (end_ev && act_rd_q && rh_full_q) begin
      rh_full_q <= 1'b0;
    end else if (!rh_full_q && cr_valid_i) begin
      rh_full_q <= 1'b1;
      rh_data_q <= cr_data_i;
    end
  end

  assign cr_ready_o = ~rh_full_q;
  assign hdata_o    = rh_data_q;
  assign hdata_oe_o = act_q & act_rd_q;

  cop_xfer_chan u_chan (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (op_start_i),
    .fmt_i       (op_fmt_i),
    .xfer_begin_i(begin_ev && s_cmd == CMD_DATA),
    .xfer_end_i  (end_ev && act_cmd_q == CMD_DATA),
    .ack_rise_i  (ack_rise),
    .cnt_only_i  (cnt_only_i),
    .req_o       (req_o)
  );

  cop_busy_ctl u_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_end_i(end_ev && !act_rd_q && act_cmd_q == CMD_INSTR),
    .done_i     (exec_done_i),
    .err_i      (exec_err_i),
    .busy_o     (busy_o),
    .err_o      (err_o)
  );

  // R1: nothing starts while the device is not selected
  a_r1_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (s_sel_n || !s_sel)) |=> !act_q);

  // R2: the no-action command never starts a transfer
  a_r2_cmd_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && s_cmd == CMD_NONE) |=> !act_q);

  // R3: a stalled write word stays put
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid_o && !cw_ready_i) |=> (cw_valid_o && $stable(cw_data_o) && $stable(cw_cmd_o)));

  // R3: input assumption, the core drains before the next write begins
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid_o && !cw_ready_i) |-> !(begin_ev && wr_fall));

  // R4: the read drive only opens after a seen read strobe
  a_r4_oe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdata_oe_o) |-> $past(rd_fall));
endmodule

// File: tb/cop_host_if_bench.sv
`timescale 1ns/1ps
module cop_host_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_lo_n = 1'b1, sel_hi = 1'b0;
  logic [1:0]  cmd = 2'b11;
  logic        rd_n = 1'b1, wr_n = 1'b1, ack = 1'b0, cnt_only = 1'b0;
  logic [15:0] hdata = '0;
  logic [15:0] hdata_o;
  logic        hdata_oe, busy, err, req;
  logic        cw_valid, cw_ready = 1'b1;
  logic [15:0] cw_data;
  logic [1:0]  cw_cmd;
  logic        cr_valid = 1'b0, cr_ready;
  logic [15:0] cr_data = '0;
  logic        op_start = 1'b0;
  logic [1:0]  op_fmt = '0;
  logic        done_p = 1'b0, err_l = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cop_host_if u_cop_host_if (
    .clk(clk), .rst_n(rst_n), .sel_lo_n_i(sel_lo_n), .sel_hi_i(sel_hi), .cmd_i(cmd),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .ack_i(ack), .cnt_only_i(cnt_only), .hdata_i(hdata),
    .hdata_o(hdata_o), .hdata_oe_o(hdata_oe), .busy_o(busy), .err_o(err), .req_o(req),
    .cw_valid_o(cw_valid), .cw_ready_i(cw_ready), .cw_data_o(cw_data), .cw_cmd_o(cw_cmd),
    .cr_valid_i(cr_valid), .cr_ready_o(cr_ready), .cr_data_i(cr_data),
    .op_start_i(op_start), .op_fmt_i(op_fmt), .exec_done_i(done_p), .exec_err_i(err_l)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle3();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic strobe_down(input bit is_rd, input logic sl_n, input logic sh,
                             input logic [1:0] c, input logic [15:0] d);
    @(negedge clk);
    sel_lo_n = sl_n; sel_hi = sh; cmd = c; hdata = d;
    @(negedge clk);
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    settle3();
  endtask

  task automatic strobe_up();
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    settle3();
    @(negedge clk);
    sel_lo_n = 1'b1; sel_hi = 1'b0; cmd = 2'b11;
  endtask

  task automatic start_op(input logic [1:0] f);
    @(negedge clk);
    op_start = 1'b1; op_fmt = f;
    @(posedge clk); #1;
    chk("R7 req after start", req, 1);
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic data_word(input string tag, input logic exp_req_after);
    strobe_down(0, 1'b0, 1'b1, 2'b01, 16'h0F0F);
    chk({tag, " R8 req drops at strobe"}, req, 0);
    strobe_up();
    chk({tag, " R8 req after word"}, req, exp_req_after);
  endtask

  task automatic t_reset();
    chk("R12 busy", busy, 0);
    chk("R12 err", err, 0);
    chk("R12 req", req, 0);
    chk("R12 oe", hdata_oe, 0);
    chk("R12 cw_valid", cw_valid, 0);
    chk("R12 cr_ready", cr_ready, 1);
  endtask

  task automatic t_write_stream();
    strobe_down(0, 1'b0, 1'b1, 2'b10, 16'hA5C3);
    chk("R3 valid", cw_valid, 1);
    chk("R3 data", cw_data, 16'hA5C3);
    chk("R3 cmd", cw_cmd, 2);
    @(posedge clk); #1;
    chk("R3 single word", cw_valid, 0);
    strobe_up();
    chk("R3 no second word", cw_valid, 0);
    chk("R5 aux write leaves busy", busy, 0);
    // back-pressure
    @(negedge clk); cw_ready = 1'b0;
    strobe_down(0, 1'b0, 1'b1, 2'b10, 16'h1234);
    chk("R3 bp valid", cw_valid, 1);
    repeat (4) @(posedge clk); #1;
    chk("R3 bp held", cw_valid, 1);
    chk("R3 bp data stable", cw_data, 16'h1234);
    strobe_up();
    @(negedge clk); cw_ready = 1'b1;
    @(posedge clk); #1;
    chk("R3 drained", cw_valid, 0);
  endtask

  task automatic t_unselected();
    strobe_down(0, 1'b1, 1'b1, 2'b00, 16'h1111);
    chk("R1 sel_lo_n high no word", cw_valid, 0);
    strobe_up();
    chk("R1 sel_lo_n high no busy", busy, 0);
    strobe_down(0, 1'b0, 1'b0, 2'b00, 16'h2222);
    chk("R1 sel_hi low no word", cw_valid, 0);
    strobe_up();
    chk("R1 sel_hi low no busy", busy, 0);
    strobe_down(1, 1'b1, 1'b0, 2'b01, 16'h0);
    chk("R1 unselected read no drive", hdata_oe, 0);
    strobe_up();
  endtask

  task automatic t_cmd_none();
    strobe_down(0, 1'b0, 1'b1, 2'b11, 16'h3333);
    chk("R2 cmd 11 no word", cw_valid, 0);
    strobe_up();
    chk("R2 cmd 11 no busy", busy, 0);
    strobe_down(1, 1'b0, 1'b1, 2'b11, 16'h0);
    chk("R2 cmd 11 no read drive", hdata_oe, 0);
    strobe_up();
  endtask

  task automatic t_read();
    @(negedge clk); cr_valid = 1'b1; cr_data = 16'hBEEF;
    @(posedge clk); #1;
    chk("R4 hold full", cr_ready, 0);
    @(negedge clk); cr_valid = 1'b0;
    strobe_down(1, 1'b0, 1'b1, 2'b10, 16'h0);
    chk("R4 oe on", hdata_oe, 1);
    chk("R4 data", hdata_o, 16'hBEEF);
    strobe_up();
    chk("R4 oe off", hdata_oe, 0);
    chk("R4 hold emptied", cr_ready, 1);
  endtask

  task automatic t_busy();
    strobe_down(0, 1'b0, 1'b1, 2'b00, 16'h00D9);
    chk("R5 busy not before completion", busy, 0);
    strobe_up();
    chk("R5 busy set", busy, 1);
    repeat (5) @(posedge clk); #1;
    chk("R5 busy held", busy, 1);
    @(negedge clk); done_p = 1'b1;
    @(posedge clk); #1;
    chk("R5 busy cleared by done", busy, 0);
    @(negedge clk); done_p = 1'b0;
  endtask

  task automatic t_error();
    strobe_down(0, 1'b0, 1'b1, 2'b00, 16'h00E1);
    strobe_up();
    chk("R6 busy before error", busy, 1);
    @(negedge clk); err_l = 1'b1;
    @(posedge clk); #1;
    chk("R6 err set", err, 1);
    chk("R6 busy still set", busy, 1);
    @(posedge clk); #1;
    chk("R6 busy released after err", busy, 0);
    @(negedge clk); err_l = 1'b0;
    @(posedge clk); #1;
    chk("R6 err follows", err, 0);
  endtask

  task automatic t_fmt(input logic [1:0] f, input int words);
    start_op(f);
    for (int i = 0; i < words; i++)
      data_word("R7 count", (i < words - 1) ? 1'b1 : 1'b0);
    repeat (5) @(posedge clk); #1;
    chk("R8 channel idle", req, 0);
  endtask

  task automatic t_ack_last();
    start_op(2'b11);
    @(negedge clk); ack = 1'b1;
    settle3();
    chk("R9 ack drops req on last word", req, 0);
    @(negedge clk); ack = 1'b0;
    repeat (3) @(posedge clk);
    data_word("R9", 1'b0);
  endtask

  task automatic t_ack_early();
    start_op(2'b00);
    @(negedge clk); ack = 1'b1;
    settle3();
    chk("R10 early ack ignored", req, 1);
    @(negedge clk); ack = 1'b0;
    repeat (3) @(posedge clk);
    data_word("R10", 1'b1);
    @(negedge clk); ack = 1'b1;
    settle3();
    chk("R9 ack on second word drops req", req, 0);
    @(negedge clk); ack = 1'b0;
    repeat (3) @(posedge clk);
    data_word("R10 tail", 1'b0);
  endtask

  task automatic t_cnt_only();
    @(negedge clk); cnt_only = 1'b1; ack = 1'b1;
    repeat (4) @(posedge clk);
    start_op(2'b01);
    repeat (4) @(posedge clk); #1;
    chk("R11 req held with ack high", req, 1);
    data_word("R11", 1'b1);
    @(negedge clk); ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); ack = 1'b1;
    settle3();
    chk("R11 ack edge ignored on last word", req, 1);
    data_word("R11 end by count", 1'b0);
    @(negedge clk); ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); cnt_only = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    t_reset();
    t_write_stream();
    t_unselected();
    t_cmd_none();
    t_read();
    t_busy();
    t_error();
    t_fmt(2'b00, 2);
    t_fmt(2'b01, 2);
    t_fmt(2'b10, 4);
    t_fmt(2'b11, 1);
    t_ack_last();
    t_ack_early();
    t_cnt_only();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule